// File: doc/BRIEF.md
# Banked Card-Channel Control Register File

This block is the host-facing register file of a three-channel card interface controller. A host reaches 16 byte-wide addresses through a write strobe, a read strobe, a 4-bit address and write data. Read data comes back one clock after the read strobe. A card-select register holds a one-hot channel field. That field decides which of three per-channel copies a banked address reaches: channel A, channel B or the auxiliary channel C.

Two addresses are split by direction. At one of them a read returns received data and a write stores transmit data. At the other a read returns a hardware status byte and a write stores a FIFO-control byte. Hardware status and received data enter through capture strobes. All control values, including every per-channel copy, are exported so that the logic downstream can use them.

Top module: `card_regbank`

## Requirements
- R1: After a synchronous reset the card-select register (00h) holds 30h. The power register (07h) of channels A and B holds 30h. Status 0Ch reads 50h and status 0Fh reads 10h. Every other register holds 00h.
- R2: Bits 2:0 of 00h form the select field: 001 is channel A, 010 is channel B and 100 is channel C. Reads and writes at 01h, 02h, 03h, 05h and 06h reach only the selected channel's copy. The copies are exported as `chan_regs[ch][slot]` with ch 0=A, 1=B, 2=C and slots 0..4 = 01h, 02h, 03h, 05h, 06h.
- R3: A select field that is not one-hot drops every write to the banked addresses (01h, 02h, 03h, 05h, 06h, 07h), and reads of those addresses return 00h.
- R4: 07h exists only for channels A and B and is exported as slot 5. With channel C selected, a write to 07h changes nothing and a read returns 00h. Slot 5 of channel C is always 00h.
- R5: A read of 0Dh returns the receive register, which `rx_load` loads from `rx_data_in`. A write to 0Dh loads the separate transmit register `tx_o`.
- R6: A read of 0Ch returns the status register. A write to 0Ch loads the separate FIFO-control register `fctl_o`.
- R7: 09h, 0Ah and 0Bh are write-only and form the 24-bit `reload_o`, with 09h as the least significant byte. Reads of these addresses return 00h.
- R8: Unimplemented bits ignore writes and read as 0. Implemented bits are: 01h bits 5:0; 06h every bit except bit 4; 07h bits 5:0; the FIFO-control register bits 6:4 and 2:0. All other registers implement all 8 bits.
- R9: A read of 04h returns 00h. Host writes to 0Eh and 0Fh have no effect.
- R10: `hw_upd` loads `stat_c_in`, `stat_e_in` and `stat_f_in` into the status registers read at 0Ch, 0Eh and 0Fh.
- R11: `rdata` is registered. It shows the addressed value in the cycle after `rd_en` and 00h after any cycle without `rd_en`. When a read and a write hit the same address in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_load | input | 1 | Load receive register |
| rx_data_in | input | 8 | Received byte |
| hw_upd | input | 1 | Capture status inputs |
| stat_c_in | input | 8 | Status for 0Ch |
| stat_e_in | input | 8 | Status for 0Eh |
| stat_f_in | input | 8 | Status for 0Fh |
| csr_o | output | 8 | Card-select register |
| chan_regs | output | 3x6x8 | Per-channel banked registers |
| tctl_o | output | 8 | Timeout-control register (08h) |
| reload_o | output | 24 | Timeout reload value |
| fctl_o | output | 8 | FIFO-control register |
| tx_o | output | 8 | Transmit register |

## Verification
The bench builds the block with its default reset-value parameters. These defaults put 30h in the select register, so the bench starts from a select field that is not one-hot. That makes the blocked-bank path reachable straight out of reset. Random select values, including the illegal ones, alternate with legal channel choices. This covers every channel-by-address combination, and it reaches the channel C entry of 07h that is absent.

// File: rtl/card_regbank_pkg.sv
package card_regbank_pkg;

    localparam int NCH   = 3;
    localparam int NSLOT = 6;
    localparam int CHW   = $clog2(NCH);

    typedef logic [7:0] byte_t;

    typedef enum logic [3:0] {
        A_CSEL  = 4'h0, A_CCTL  = 4'h1, A_PDAT  = 4'h2, A_UCTL2 = 4'h3,
        A_HOLE  = 4'h4, A_GUARD = 4'h5, A_UCTL1 = 4'h6, A_PWR   = 4'h7,
        A_TCTL  = 4'h8, A_RLD0  = 4'h9, A_RLD1  = 4'hA, A_RLD2  = 4'hB,
        A_STFC  = 4'hC, A_DATA  = 4'hD, A_USTAT = 4'hE, A_HSTAT = 4'hF
    } addr_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] idx;
    } slot_t;

    typedef struct packed {
        logic                       csr;
        logic [NCH-1:0][NSLOT-1:0]  slot;
        logic                       tctl;
        logic [2:0]                 rld;
        logic                       fctl;
        logic                       tx;
    } wr_dec_t;

    localparam byte_t FCTL_MASK = 8'h77;

    function automatic slot_t slot_of(input logic [3:0] a);
        slot_t s;
        s = '0;
        case (a)
            A_CCTL:  s = '{1'b1, 3'd0};
            A_PDAT:  s = '{1'b1, 3'd1};
            A_UCTL2: s = '{1'b1, 3'd2};
            A_GUARD: s = '{1'b1, 3'd3};
            A_UCTL1: s = '{1'b1, 3'd4};
            A_PWR:   s = '{1'b1, 3'd5};
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic byte_t slot_mask(input int unsigned k);
        case (k)
            0:       return 8'h3F;
            4:       return 8'hEF;
            5:       return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic sel_ok(input logic [NCH-1:0] s);
        return $countones(s) == 1;
    endfunction

    function automatic logic [CHW-1:0] sel_idx(input logic [NCH-1:0] s);
        logic [CHW-1:0] r;
        r = '0;
        for (int i = 0; i < NCH; i++)
            if (s[i]) r = CHW'(i);
        return r;
    endfunction

endpackage

// File: rtl/card_regbank_dec.sv
module card_regbank_dec
    import card_regbank_pkg::*;
#(
    parameter logic [NCH-1:0] PWR_CH_MASK = 3'b011
) (
    input  logic           wr_en,
    input  logic [3:0]     addr,
    input  logic [NCH-1:0] sel,
    output wr_dec_t        dec
);

    slot_t          sl;
    logic [CHW-1:0] ch;
    logic           ok;

    always_comb begin
        sl  = slot_of(addr);
        ch  = sel_idx(sel);
        ok  = sel_ok(sel);
        dec = '0;
        if (wr_en) begin
            case (addr)
                A_CSEL:  dec.csr    = 1'b1;
                A_TCTL:  dec.tctl   = 1'b1;
                A_RLD0:  dec.rld[0] = 1'b1;
                A_RLD1:  dec.rld[1] = 1'b1;
                A_RLD2:  dec.rld[2] = 1'b1;
                A_STFC:  dec.fctl   = 1'b1;
                A_DATA:  dec.tx     = 1'b1;
                default: ;
            endcase
            if (sl.hit && ok && (sl.idx != 3'(NSLOT-1) || PWR_CH_MASK[ch]))
                dec.slot[ch][sl.idx] = 1'b1;
        end
    end

endmodule

// File: rtl/card_regbank_chan.sv
module card_regbank_chan
    import card_regbank_pkg::*;
#(
    parameter bit    HAS_PWR = 1'b1,
    parameter byte_t PWR_RST = 8'h30
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSLOT-1:0]       we,
    input  byte_t                  wdata,
    output logic [NSLOT-1:0][7:0]  regs
);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam byte_t MASK = slot_mask(k);
        localparam byte_t RSTV = (k == NSLOT-1) ? PWR_RST : 8'h00;
        if (k == NSLOT-1 && !HAS_PWR) begin : g_absent
            assign regs[k] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)        regs[k] <= RSTV;
                else if (we[k]) regs[k] <= wdata & MASK;
            end
            AST_UNIMPL_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
                (regs[k] & ~MASK) == 8'h00); // R8
        end
    end

endmodule

// File: rtl/card_regbank.sv
module card_regbank
    import card_regbank_pkg::*;
#(
    parameter byte_t CSR_RST    = 8'h30,
    parameter byte_t PWR_RST    = 8'h30,
    parameter byte_t STAT_C_RST = 8'h50,
    parameter byte_t STAT_E_RST = 8'h00,
    parameter byte_t STAT_F_RST = 8'h10
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [3:0]                     addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    input  logic                           rx_load,
    input  logic [7:0]                     rx_data_in,
    input  logic                           hw_upd,
    input  logic [7:0]                     stat_c_in,
    input  logic [7:0]                     stat_e_in,
    input  logic [7:0]                     stat_f_in,
    output logic [7:0]                     csr_o,
    output logic [NCH-1:0][NSLOT-1:0][7:0] chan_regs,
    output logic [7:0]                     tctl_o,
    output logic [23:0]                    reload_o,
    output logic [7:0]                     fctl_o,
    output logic [7:0]                     tx_o
);

    localparam logic [NCH-1:0] PWR_CH_MASK = 3'b011;

    wr_dec_t dec;
    byte_t   rx_q, st_c, st_e, st_f, rd_mux;

    card_regbank_dec #(.PWR_CH_MASK(PWR_CH_MASK)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (csr_o[NCH-1:0]),
        .dec   (dec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        card_regbank_chan #(.HAS_PWR(PWR_CH_MASK[c]), .PWR_RST(PWR_RST)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .we    (dec.slot[c]),
            .wdata (wdata),
            .regs  (chan_regs[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_o    <= CSR_RST;
            tctl_o   <= '0;
            reload_o <= '0;
            fctl_o   <= '0;
            tx_o     <= '0;
        end else begin
            if (dec.csr)    csr_o          <= wdata;
            if (dec.tctl)   tctl_o         <= wdata;
            if (dec.rld[0]) reload_o[7:0]  <= wdata;
            if (dec.rld[1]) reload_o[15:8] <= wdata;
            if (dec.rld[2]) reload_o[23:16]<= wdata;
            if (dec.fctl)   fctl_o         <= wdata & FCTL_MASK;
            if (dec.tx)     tx_o           <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
            st_c <= STAT_C_RST;
            st_e <= STAT_E_RST;
            st_f <= STAT_F_RST;
        end else begin
            if (rx_load) rx_q <= rx_data_in;
            if (hw_upd) begin
                st_c <= stat_c_in;
                st_e <= stat_e_in;
                st_f <= stat_f_in;
            end
        end
    end

    slot_t rsl;
    always_comb begin
        rsl    = slot_of(addr);
        rd_mux = '0;
        case (addr)
            A_CSEL:  rd_mux = csr_o;
            A_TCTL:  rd_mux = tctl_o;
            A_STFC:  rd_mux = st_c;
            A_DATA:  rd_mux = rx_q;
            A_USTAT: rd_mux = st_e;
            A_HSTAT: rd_mux = st_f;
            default: begin
                if (rsl.hit && sel_ok(csr_o[NCH-1:0]))
                    rd_mux = chan_regs[sel_idx(csr_o[NCH-1:0])][rsl.idx];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_en ? rd_mux : 8'h00;
    end

    AST_BANK_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec.slot)); // R2
    AST_BADSEL_NO_BANK_WR: assert property (@(posedge clk) disable iff (rst)
        !sel_ok(csr_o[NCH-1:0]) |=> $stable(chan_regs)); // R3
    AST_PWR_C_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_PWR && csr_o[NCH-1:0] == 3'b100)
        |=> $stable(chan_regs[0][NSLOT-1]) && $stable(chan_regs[1][NSLOT-1])); // R4
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_RLD0 || addr == A_RLD1 || addr == A_RLD2))
        |=> rdata == 8'h00); // R7
    AST_STATUS_HOST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_HSTAT && !hw_upd) |=> $stable(st_f)); // R9
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == 8'h00); // R11

endmodule

// File: tb/sim_card_regbank.sv
module sim_card_regbank;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, wr_en, rd_en, rx_load, hw_upd;
    logic [3:0]  addr;
    logic [7:0]  wdata, rdata, rx_data_in, stat_c_in, stat_e_in, stat_f_in;
    logic [7:0]  csr_o, tctl_o, fctl_o, tx_o;
    logic [23:0] reload_o;
    logic [2:0][5:0][7:0] chan_regs;

    card_regbank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_load(rx_load), .rx_data_in(rx_data_in),
        .hw_upd(hw_upd), .stat_c_in(stat_c_in), .stat_e_in(stat_e_in),
        .stat_f_in(stat_f_in), .csr_o(csr_o), .chan_regs(chan_regs),
        .tctl_o(tctl_o), .reload_o(reload_o), .fctl_o(fctl_o), .tx_o(tx_o)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] m_csr, m_tctl, m_fctl, m_tx, m_rx;
    logic [7:0] m_bank [3][6];
    logic [7:0] m_rld [3];
    logic [7:0] m_st [3];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(int k);
        case (k)
            0: return 8'h3F;
            4: return 8'hEF;
            5: return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int sel_ch(logic [7:0] c);
        case (c[2:0])
            3'b001: return 0;
            3'b010: return 1;
            3'b100: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic int slot_of(logic [3:0] a);
        case (a)
            4'h1: return 0;
            4'h2: return 1;
            4'h3: return 2;
            4'h5: return 3;
            4'h6: return 4;
            4'h7: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] a);
        if (slot_of(a) >= 0) return (sel_ch(m_csr) < 0) ? "R3" : (a == 4'h7 ? "R4" : "R2");
        case (a)
            4'h9, 4'hA, 4'hB: return "R7";
            4'hC: return "R6";
            4'hD: return "R5";
            4'h4, 4'hE, 4'hF: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [7:0] model_rd(logic [3:0] a);
        int ch, k;
        k  = slot_of(a);
        ch = sel_ch(m_csr);
        if (k >= 0) begin
            if (ch < 0 || (k == 5 && ch == 2)) return 8'h00;
            return m_bank[ch][k];
        end
        case (a)
            4'h0: return m_csr;
            4'h8: return m_tctl;
            4'hC: return m_st[0];
            4'hD: return m_rx;
            4'hE: return m_st[1];
            4'hF: return m_st[2];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(logic [3:0] a, logic [7:0] d);
        int ch, k;
        k  = slot_of(a);
        ch = sel_ch(m_csr);
        if (k >= 0) begin
            if (ch >= 0 && !(k == 5 && ch == 2)) m_bank[ch][k] = d & mask_of(k);
        end else begin
            case (a)
                4'h0: m_csr = d;
                4'h8: m_tctl = d;
                4'h9: m_rld[0] = d;
                4'hA: m_rld[1] = d;
                4'hB: m_rld[2] = d;
                4'hC: m_fctl = d & 8'h77;
                4'hD: m_tx = d;
                default: ;
            endcase
        end
    endtask

    task automatic model_reset();
        m_csr = 8'h30; m_tctl = 0; m_fctl = 0; m_tx = 0; m_rx = 0;
        for (int c = 0; c < 3; c++) for (int k = 0; k < 6; k++)
            m_bank[c][k] = (k == 5 && c < 2) ? 8'h30 : 8'h00;
        for (int i = 0; i < 3; i++) m_rld[i] = 0;
        m_st[0] = 8'h50; m_st[1] = 8'h00; m_st[2] = 8'h10;
    endtask

    // called at a negedge; returns at the following negedge
    task automatic op(bit w, bit r, logic [3:0] a, logic [7:0] d, string req);
        logic [7:0] exp;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        exp = model_rd(a);
        if (w) model_wr(a, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        if (r) chk(req, $sformatf("read %0h", a), rdata, exp);
        else   chk("R11", "idle rdata", rdata, 8'h00);
    endtask

    task automatic hw(logic [7:0] c, logic [7:0] e, logic [7:0] f, bit rl, logic [7:0] rx);
        hw_upd = 1; stat_c_in = c; stat_e_in = e; stat_f_in = f;
        rx_load = rl; rx_data_in = rx;
        @(posedge clk);
        @(negedge clk);
        hw_upd = 0; rx_load = 0;
        m_st[0] = c; m_st[1] = e; m_st[2] = f;
        if (rl) m_rx = rx;
    endtask

    task automatic chk_exports(string req);
        for (int c = 0; c < 3; c++) for (int k = 0; k < 6; k++)
            chk(req, $sformatf("chan_regs[%0d][%0d]", c, k), chan_regs[c][k], m_bank[c][k]);
        chk(req, "csr_o", csr_o, m_csr);
        chk(req, "tctl_o", tctl_o, m_tctl);
        chk(req, "reload_o", reload_o, {m_rld[2], m_rld[1], m_rld[0]});
        chk(req, "fctl_o", fctl_o, m_fctl);
        chk(req, "tx_o", tx_o, m_tx);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d;
        logic [3:0] a;
        void'($urandom(32'd20240611));
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        rx_load = 0; rx_data_in = 0; hw_upd = 0;
        stat_c_in = 0; stat_e_in = 0; stat_f_in = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset values through reads and exports
        for (int i = 0; i < 16; i++) op(0, 1, 4'(i), 8'h00, "R1");
        chk_exports("R1");

        // R2/R8: channel A, unimplemented bits of 01h
        op(1, 0, 4'h0, 8'h01, "R2");
        op(1, 0, 4'h1, 8'hFF, "R8");
        op(0, 1, 4'h1, 8'h00, "R8");
        op(1, 0, 4'h6, 8'hFF, "R8");
        op(0, 1, 4'h6, 8'h00, "R8");
        op(1, 0, 4'h2, 8'hA5, "R2");
        // R2: channel B copy independent
        op(1, 0, 4'h0, 8'h02, "R2");
        op(1, 0, 4'h2, 8'h5A, "R2");
        op(0, 1, 4'h2, 8'h00, "R2");
        chk_exports("R2");
        // R4: channel C power register absent
        op(1, 0, 4'h0, 8'h04, "R4");
        op(1, 0, 4'h7, 8'hAA, "R4");
        op(0, 1, 4'h7, 8'h00, "R4");
        chk_exports("R4");
        // R3: illegal select blocks bank access
        op(1, 0, 4'h0, 8'h03, "R3");
        op(1, 0, 4'h5, 8'h77, "R3");
        op(0, 1, 4'h5, 8'h00, "R3");
        op(0, 1, 4'h2, 8'h00, "R3");
        chk_exports("R3");
        // R5: data address split
        hw(8'h50, 8'h00, 8'h10, 1, 8'h3C);
        op(1, 0, 4'hD, 8'hC3, "R5");
        op(0, 1, 4'hD, 8'h00, "R5");
        chk("R5", "tx_o", tx_o, 8'hC3);
        // R6: status / FIFO control split
        op(1, 0, 4'hC, 8'hFF, "R6");
        op(0, 1, 4'hC, 8'h00, "R6");
        chk("R6", "fctl_o", fctl_o, 8'h77);
        // R7: reload order and write-only reads
        op(1, 0, 4'h9, 8'h11, "R7");
        op(1, 0, 4'hA, 8'h22, "R7");
        op(1, 1, 4'hB, 8'h33, "R7");
        op(0, 1, 4'h9, 8'h00, "R7");
        chk("R7", "reload_o", reload_o, 24'h332211);
        // R9: hole and read-only status
        op(1, 1, 4'h4, 8'hFF, "R9");
        op(1, 0, 4'hF, 8'hFF, "R9");
        op(1, 0, 4'hE, 8'hFF, "R9");
        op(0, 1, 4'hF, 8'h00, "R9");
        op(0, 1, 4'hE, 8'h00, "R9");
        // R10: status capture
        hw(8'h9C, 8'h3E, 8'hE7, 0, 8'h00);
        op(0, 1, 4'hC, 8'h00, "R10");
        op(0, 1, 4'hE, 8'h00, "R10");
        op(0, 1, 4'hF, 8'h00, "R10");
        // R11: read and write together return old value
        op(1, 0, 4'h0, 8'h02, "R11");
        op(1, 1, 4'h2, 8'h0F, "R11");
        op(0, 1, 4'h2, 8'h00, "R11");
        op(0, 0, 4'h2, 8'h00, "R11");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            a = 4'($urandom_range(0, 15));
            d = 8'($urandom);
            if (a == 4'h0 && $urandom_range(0, 3) != 0)
                d = {d[7:3], 3'(1 << $urandom_range(0, 2))};
            if ($urandom_range(0, 15) == 0)
                hw(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
            op(1'($urandom), 1'($urandom), a, d, req_of(a));
        end
        chk_exports("R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule